// File: doc/BRIEF.md
# I2C Read-Only Slave Transmitter

This block is the target side of an I2C link for 7-bit addressing, and it serves only master-read transfers. It samples the bus through synchronisers running on the system clock. It finds start and stop conditions, shifts in the address byte and compares its upper seven bits with `own_addr`. When the address matches and the direction bit asks for a read, it acknowledges. It then holds SCL low, which holds off the master until local software has supplied a byte.

Software loads `tx_data` with a `tx_wr` pulse and then lets the bus run again by pulsing `rel_set`. The byte goes out most significant bit first. The master's acknowledge bit chooses what happens next. An acknowledge stretches the clock again for the next byte. A not-acknowledge ends the transfer and returns the block to start detection. The `irq_flag` output marks the end of every byte, and software must clear it.

Both bus lines are open-drain. The block only reports, through `scl_drive_low` and `sda_drive_low`, when it pulls a line down. A host write is ignored while the shift register is busy, which covers address reception, the one-cycle data setup and data shifting. The address copy placed in `buf_q` does not set `buf_full`.

Top module: `i2c_rd_slave`

## Requirements
- R1: Out of reset, neither line is pulled low and `irq_flag`, `buf_full` and `rw_flag` are all 0.
- R2: For an address byte whose bits 7..1 equal `own_addr` and whose bit 0 (direction) is 1, SDA is pulled low through the ninth clock, `rw_flag` becomes 1 and `buf_q` holds the whole received address byte.
- R3: After the address acknowledge, SCL is held low until software releases it.
- R4: A `rel_set` pulse while `buf_full` is 0 has no effect, and SCL stays held low.
- R5: A `tx_wr` pulse in a waiting state copies `tx_data` into `buf_q` and sets `buf_full`. `buf_full` returns to 0 once the eighth data bit has been shifted out.
- R6: Data bits leave most significant bit first. SDA changes only while SCL is low, so the master reads the loaded byte unchanged.
- R7: `irq_flag` is set at the falling edge of the ninth clock of every acknowledged address byte and every data byte. It then stays set until an `irq_clr` pulse.
- R8: An acknowledge (SDA low at the ninth rising edge) from the master makes the block hold SCL low again until the next load and release.
- R9: A not-acknowledge (SDA high at the ninth rising edge) ends the transfer. `rw_flag` and `buf_full` drop to 0, both lines are released and SCL is not stretched again.
- R10: An address whose upper bits differ from `own_addr`, or whose direction bit is 0, gets no acknowledge, sets no flag and leaves both lines released.
- R11: A stop condition, or a start condition in the middle of a byte, abandons it, clears `rw_flag` and restarts address reception. The next address is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge or data zero) |
| own_addr | input | 7 | Address this slave answers to |
| tx_wr | input | 1 | One-cycle pulse: load `tx_data` for transmission |
| tx_data | input | 8 | Byte to transmit |
| rel_set | input | 1 | One-cycle pulse: release the stretched clock |
| irq_clr | input | 1 | One-cycle pulse: clear `irq_flag` |
| buf_q | output | 8 | Buffer contents: last loaded byte or received address byte |
| buf_full | output | 1 | A loaded byte has not yet been fully sent |
| rw_flag | output | 1 | A read transfer to this slave is in progress |
| irq_flag | output | 1 | Byte-complete event flag |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 instead of the default 2. The longer path from pad to decision checks that edge and start/stop detection, and the point where SDA may change, still line up once an extra synchroniser flop adds latency. The bus master runs with a half-period of 20 system clocks. With that spacing every stretch, release and acknowledge sample can be observed at the pins: the line stays low while software is idle and rises only after a load and release. Abort cases are placed inside the address byte, where the master still owns SDA.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_ADDR,   // shifting in address byte
    ST_AACK,   // driving address acknowledge
    ST_HOLD,   // stretching SCL, waiting for host
    ST_SETUP,  // one cycle: present MSB while SCL still held
    ST_SEND,   // shifting data out
    ST_MACK    // sampling master acknowledge
  } rd_state_t;

  // Upper seven bits of the received byte against the configured address.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [ADDR_W-1:0] own);
    return rx[BYTE_W-1:1] == own;
  endfunction

  // Direction bit: 1 requests a read from this slave.
  function automatic logic read_req(input logic [BYTE_W-1:0] rx);
    return rx[0];
  endfunction
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rd_shifter.sv
module i2c_rd_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shl_in,
  input  logic         in_bit,
  input  logic         shl_out,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load)    q <= load_val;
    else if (shl_in)  q <= {q[W-2:0], in_bit};
    else if (shl_out) q <= {q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              rel_set,
  input  logic              irq_clr,
  input  logic [BYTE_W-1:0] sh_q,
  output logic              sh_load,
  output logic              sh_in,
  output logic              sh_out,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] buf_q,
  output logic              buf_full,
  output logic              rw_flag,
  output logic              irq_flag,
  output logic              byte_done_ev,
  output logic              nack_ev
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(BYTE_W - 1);

  rd_state_t        state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             ckp;
  logic             mack_bit;

  logic abort, addr_done, addr_ok, aack_done, send_last, mack_done, busy;

  assign abort     = start_ev | stop_ev;
  assign addr_done = (state == ST_ADDR) && scl_fall && (cnt == RX_LAST);
  assign addr_ok   = addr_done && addr_hit(sh_q, own_addr) && read_req(sh_q);
  assign aack_done = (state == ST_AACK) && scl_fall;
  assign send_last = (state == ST_SEND) && scl_fall && (cnt == TX_LAST);
  assign mack_done = (state == ST_MACK) && scl_fall;
  assign busy      = (state == ST_ADDR) || (state == ST_SETUP) || (state == ST_SEND);

  assign nack_ev      = mack_done && mack_bit;
  assign byte_done_ev = aack_done || mack_done;

  assign sh_load = tx_wr && !busy;
  assign sh_in   = (state == ST_ADDR) && scl_rise && (cnt < RX_LAST);
  assign sh_out  = (state == ST_SEND) && scl_fall && (cnt != TX_LAST);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  nxt = ST_IDLE;
      ST_ADDR:  if (addr_done) nxt = addr_ok ? ST_AACK : ST_IDLE;
      ST_AACK:  if (scl_fall) nxt = ST_HOLD;
      ST_HOLD:  if (ckp) nxt = ST_SETUP;
      ST_SETUP: nxt = ST_SEND;
      ST_SEND:  if (send_last) nxt = ST_MACK;
      ST_MACK:  if (scl_fall) nxt = mack_bit ? ST_IDLE : ST_HOLD;
      default:  nxt = ST_IDLE;
    endcase
    if (start_ev)     nxt = ST_ADDR;
    else if (stop_ev) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ckp      <= 1'b0;
      mack_bit <= 1'b1;
      buf_q    <= '0;
      buf_full <= 1'b0;
      rw_flag  <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      state <= nxt;

      if (abort || (state == ST_SETUP)) cnt <= '0;
      else if (sh_in || sh_out)         cnt <= cnt + 1'b1;

      if (abort || nack_ev || (state == ST_SETUP)) ckp <= 1'b0;
      else if (rel_set && buf_full)                ckp <= 1'b1;

      if ((state == ST_MACK) && scl_rise) mack_bit <= sda_s;

      if (sh_load)      buf_q <= tx_data;
      else if (addr_ok) buf_q <= sh_q;

      if (nack_ev)        buf_full <= 1'b0;
      else if (sh_load)   buf_full <= 1'b1;
      else if (send_last) buf_full <= 1'b0;

      if (abort || nack_ev) rw_flag <= 1'b0;
      else if (addr_ok)     rw_flag <= 1'b1;

      if (byte_done_ev) irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  assign scl_oe = (state == ST_HOLD) || (state == ST_SETUP);
  assign sda_oe = (state == ST_AACK) ||
                  (((state == ST_SETUP) || (state == ST_SEND)) && !sh_q[BYTE_W-1]);
endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave
  import i2c_rd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              rel_set,
  input  logic              irq_clr,
  output logic [BYTE_W-1:0] buf_q,
  output logic              buf_full,
  output logic              rw_flag,
  output logic              irq_flag
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              sh_load, sh_in, sh_out;
  logic [BYTE_W-1:0] sh_q;
  logic              byte_done_ev, nack_ev;

  i2c_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_rd_shifter #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (tx_data),
    .shl_in   (sh_in),
    .in_bit   (sda_s),
    .shl_out  (sh_out),
    .q        (sh_q)
  );

  i2c_rd_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_s        (sda_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .own_addr     (own_addr),
    .tx_wr        (tx_wr),
    .tx_data      (tx_data),
    .rel_set      (rel_set),
    .irq_clr      (irq_clr),
    .sh_q         (sh_q),
    .sh_load      (sh_load),
    .sh_in        (sh_in),
    .sh_out       (sh_out),
    .scl_oe       (scl_drive_low),
    .sda_oe       (sda_drive_low),
    .buf_q        (buf_q),
    .buf_full     (buf_full),
    .rw_flag      (rw_flag),
    .irq_flag     (irq_flag),
    .byte_done_ev (byte_done_ev),
    .nack_ev      (nack_ev)
  );
endmodule

// File: rtl/i2c_rd_slave_chk.sv
module i2c_rd_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic tx_wr,
  input logic irq_clr,
  input logic buf_full,
  input logic rw_flag,
  input logic irq_flag,
  input logic byte_done_ev,
  input logic nack_ev
);
  // R3
  stretch_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && !buf_full) |=> scl_drive_low);

  // R2
  drive_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> rw_flag);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R7
  irq_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_ev |=> irq_flag);

  // R5
  full_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> $past(tx_wr));

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> (!rw_flag && !scl_drive_low && !sda_drive_low));

  // R6
  sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_s);
endmodule

bind i2c_rd_slave i2c_rd_slave_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_s         (scl_s),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .tx_wr         (tx_wr),
  .irq_clr       (irq_clr),
  .buf_full      (buf_full),
  .rw_flag       (rw_flag),
  .irq_flag      (irq_flag),
  .byte_done_ev  (byte_done_ev),
  .nack_ev       (nack_ev)
);

// File: tb/tb_i2c_rd_slave.sv
module tb_i2c_rd_slave;
  localparam int Q = 10;
  localparam int H = 20;
  localparam logic [6:0] MY_ADDR = 7'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rel_set = 1'b0;
  logic       irq_clr = 1'b0;
  logic       scl_dl, sda_dl, buf_full, rw_flag, irq_flag;
  logic [7:0] buf_q;
  logic       scl_line, sda_line;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  assign scl_line = m_scl & ~scl_dl;
  assign sda_line = m_sda & ~sda_dl;

  i2c_rd_slave #(.SYNC_STAGES(3)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_line),
    .sda_i         (sda_line),
    .scl_drive_low (scl_dl),
    .sda_drive_low (sda_dl),
    .own_addr      (MY_ADDR),
    .tx_wr         (tx_wr),
    .tx_data       (tx_data),
    .rel_set       (rel_set),
    .irq_clr       (irq_clr),
    .buf_q         (buf_q),
    .buf_full      (buf_full),
    .rw_flag       (rw_flag),
    .irq_flag      (irq_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wait_scl_high(); wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wait_scl_high(); wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wt(Q);
    m_scl = 1'b1; wait_scl_high(); wt(H);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output logic b);
    wt(Q);
    m_scl = 1'b1; wait_scl_high(); wt(H/2);
    b = sda_line; wt(H/2);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    m_sda = 1'b1;
    get_bit(ack);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] v);
    logic b;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(nack);
    m_sda = 1'b1;
  endtask

  task automatic host_load(input logic [7:0] v);
    tx_data = v; tx_wr = 1'b1; wt(1); tx_wr = 1'b0; wt(1);
  endtask

  task automatic host_release();
    rel_set = 1'b1; wt(1); rel_set = 1'b0; wt(1);
  endtask

  task automatic host_clear_irq();
    irq_clr = 1'b1; wt(1); irq_clr = 1'b0; wt(1);
  endtask

  task automatic t_reset();
    chk("R1 scl drive", scl_dl, 0);
    chk("R1 sda drive", sda_dl, 0);
    chk("R1 irq", irq_flag, 0);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 rw_flag", rw_flag, 0);
  endtask

  task automatic t_read_two(input logic [7:0] d0, input logic [7:0] d1);
    logic       ack;
    logic [7:0] rx;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk("R2 address ack", ack, 0);
    chk("R2 rw_flag", rw_flag, 1);
    chk("R2 buf_q address", buf_q, {MY_ADDR, 1'b1});
    chk("R7 irq after address", irq_flag, 1);
    wt(25);
    chk("R7 irq held", irq_flag, 1);
    host_clear_irq();
    chk("R7 irq cleared", irq_flag, 0);
    m_scl = 1'b1; wt(30);
    chk("R3 scl stretched", scl_line, 0);
    host_release(); wt(30);
    chk("R4 release ignored without data", scl_line, 0);
    host_load(d0);
    chk("R5 buf_q loaded", buf_q, d0);
    chk("R5 buf_full set", buf_full, 1);
    host_release();
    read_byte(1'b0, rx);
    chk("R6 first byte", rx, d0);
    chk("R5 buf_full cleared", buf_full, 0);
    chk("R7 irq after data", irq_flag, 1);
    host_clear_irq();
    m_scl = 1'b1; wt(30);
    chk("R8 stretched after ack", scl_line, 0);
    host_load(d1);
    host_release();
    read_byte(1'b1, rx);
    chk("R6 second byte", rx, d1);
    chk("R7 irq after last", irq_flag, 1);
    chk("R9 rw cleared", rw_flag, 0);
    chk("R9 buf_full cleared", buf_full, 0);
    m_scl = 1'b1; wt(30);
    chk("R9 no stretch", scl_line, 1);
    chk("R9 sda released", sda_dl, 0);
    m_scl = 1'b0; wt(Q);
    host_clear_irq();
    bus_stop();
  endtask

  task automatic t_no_answer(input logic [7:0] abyte, input string tag);
    logic ack;
    bus_start();
    send_byte(abyte, ack);
    chk({"R10 no ack ", tag}, ack, 1);
    chk({"R10 rw ", tag}, rw_flag, 0);
    chk({"R10 irq ", tag}, irq_flag, 0);
    m_scl = 1'b1; wt(30);
    chk({"R10 scl free ", tag}, scl_line, 1);
    m_scl = 1'b0; wt(Q);
    bus_stop();
  endtask

  task automatic t_abort();
    logic       ack;
    logic [7:0] rx;
    logic [7:0] ab;
    ab = {MY_ADDR, 1'b1};
    bus_start();
    for (int i = 7; i >= 4; i--) put_bit(ab[i]);
    bus_stop();
    chk("R11 stop: lines free", {scl_line, sda_line}, 2'b11);
    chk("R11 stop: rw", rw_flag, 0);
    bus_start();
    for (int i = 7; i >= 5; i--) put_bit(ab[i]);
    bus_start();
    send_byte(ab, ack);
    chk("R11 restart then address ack", ack, 0);
    chk("R11 rw after restart", rw_flag, 1);
    host_clear_irq();
    host_load(8'h01);
    host_release();
    read_byte(1'b1, rx);
    chk("R6 byte after restart", rx, 8'h01);
    host_clear_irq();
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_read_two(8'hA5, 8'h3C);
    t_read_two(8'h80, 8'hFF);
    t_no_answer({MY_ADDR ^ 7'h01, 1'b1}, "other address");
    t_no_answer({MY_ADDR, 1'b0}, "write direction");
    t_abort();
    t_read_two(8'h00, 8'h7E);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule